// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM from several serial data lines that share one bit clock and one frame (left/right) clock. It returns one left and one right sample per line, each sign-extended or left-aligned to 32 bits, once per frame. Everything runs on a fast system clock. The bit clock, the frame clock and the data lines are each brought in through a two-flop synchroniser, and bit-clock rising edges are detected inside. The system clock must run at least four times the bit-clock rate.

A static two-bit format input selects one of four framings. Three are right-justified, with the word length fixed at 16, 20 or 24 bits. The fourth is I2S, with words of up to 32 bits. In every framing, data is two's complement, sent MSB first and sampled on the bit-clock rising edge.

Results leave on a valid/ready stream. The serial source cannot be paused, so back-pressure never stalls reception:
- A completed frame raises `out_valid`.
- `out_valid` stays high until a cycle with `out_ready` high.
- A frame that completes while the previous one is still held replaces it.

Top module: `serial_pcm_rx`

## Requirements
- R1: `fmt_sel` encodes the framing as follows: 0 selects right-justified 16-bit, 1 selects right-justified 20-bit, 2 selects right-justified 24-bit, and 3 selects I2S.
- R2: Right-justified channel timing.
  - Frame clock high marks the left word and low marks the right word.
  - The word's LSB is the last bit sampled before the frame-clock edge.
  - Earlier bits in the half-frame are ignored.
- R3: In right-justified mode, the output word is the low N received bits (N = 16, 20 or 24), sign-extended from bit N-1 to 32 bits.
- R4: I2S channel timing.
  - Frame clock low marks the left word and high marks the right word.
  - The MSB is the bit sampled one bit-clock period after the frame-clock edge.
  - The received bits are left-aligned, with the first received bit at bit 31.
- R5: In I2S mode, bit positions not received before the word ends read as zero. Bits beyond the 32nd in one half-frame are dropped.
- R6: Each of the `LANES` data lines is captured independently. Lane k occupies bits [32k+31:32k] of `out_left` and `out_right`.
- R7: A result is produced only when a right word completes after a left word that itself began at a frame-clock edge. The result pairs that left word with that right word. No result follows the partial frame after reset.
- R8: Output stream rules.
  - `out_valid` is held, with stable data, until `out_ready` is high.
  - It drops in the cycle after a handshake, unless a new frame completes.
  - A frame completing while `out_valid` is held overwrites the data.
- R9: While `rst_n` is low, `out_valid` is 0 and both sample buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| lrclk_in | input | 1 | Frame / channel clock (asynchronous) |
| sdata_in | input | LANES | Serial data lines, one per stereo pair |
| fmt_sel | input | 2 | Framing select (R1), static during operation |
| out_ready | input | 1 | Consumer ready |
| out_valid | output | 1 | Frame result available |
| out_left | output | 32*LANES | Left samples, lane k at bits [32k+31:32k] |
| out_right | output | 32*LANES | Right samples, lane k at bits [32k+31:32k] |

## Verification
The assertions check the stream rules on every cycle:
- `out_valid` is held while the consumer stalls.
- The sample buses stay stable while stalled, unless a new frame completes.
- `out_valid` drops after a handshake.
- The internal frame-complete strobe never lasts two cycles.

Only the bench's scenarios can show the following:
- The bit-level framing of each mode: which half is left, where the MSB and LSB sit, sign extension at each width, and I2S zero-fill and overflow dropping.
- The pairing of left with right, and the suppression of the first partial frame.
- The overwrite of a held result.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SMP_W = 32;
  localparam int CNT_W = $clog2(SMP_W) + 1;

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'd0,
    FMT_RJ20 = 2'd1,
    FMT_RJ24 = 2'd2,
    FMT_I2S  = 2'd3
  } fmt_e;

  // Turn the running shift register into a 32-bit sample for the framing.
  function automatic logic [SMP_W-1:0] word_extract(input fmt_e f,
                                                    input logic [SMP_W-1:0] sh,
                                                    input logic [CNT_W-1:0] nbits);
    logic [SMP_W-1:0] w;
    case (f)
      FMT_RJ16: w = {{(SMP_W-16){sh[15]}}, sh[15:0]};
      FMT_RJ20: w = {{(SMP_W-20){sh[19]}}, sh[19:0]};
      FMT_RJ24: w = {{(SMP_W-24){sh[23]}}, sh[23:0]};
      default: begin
        if (nbits == '0) w = '0;
        else             w = sh << (CNT_W'(SMP_W) - nbits);
      end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_s,
  input  logic             lr_s,
  input  fmt_e             fmt,
  output logic             shift_en,
  output logic             word_end,
  output logic             end_left,
  output logic [CNT_W-1:0] word_bits,
  output logic             frame_done
);
  logic             bclk_d;
  logic             bit_stb;
  logic             lr_d1;
  logic             eff_prev;
  logic             eff_now;
  logic             primed;
  logic             seen_edge;
  logic             left_ok;
  logic [CNT_W-1:0] cnt;
  logic             is_i2s;

  assign is_i2s  = (fmt == FMT_I2S);
  assign bit_stb = bclk_s & ~bclk_d;
  // I2S: the channel boundary is seen one bit late and the polarity is flipped,
  // so both framings become "1 = left, word ends at the boundary".
  assign eff_now   = is_i2s ? ~lr_d1 : lr_s;
  assign word_end  = bit_stb & primed & (eff_now != eff_prev);
  assign end_left  = eff_prev;
  assign word_bits = cnt;
  assign shift_en  = bit_stb & (word_end | ~(is_i2s & (cnt >= CNT_W'(SMP_W))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d     <= 1'b0;
      lr_d1      <= 1'b0;
      eff_prev   <= 1'b0;
      primed     <= 1'b0;
      cnt        <= '0;
      seen_edge  <= 1'b0;
      left_ok    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      bclk_d     <= bclk_s;
      frame_done <= word_end & ~end_left & left_ok;
      if (bit_stb) begin
        lr_d1    <= lr_s;
        eff_prev <= eff_now;
        primed   <= 1'b1;
        if (word_end)                  cnt <= CNT_W'(1);
        else if (cnt < CNT_W'(SMP_W))  cnt <= cnt + CNT_W'(1);
      end
      if (word_end) begin
        seen_edge <= 1'b1;
        if (end_left) left_ok <= seen_edge;
        else          left_ok <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_lane.sv
module pcm_lane
  import pcm_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             shift_en,
  input  logic             word_end,
  input  logic             end_left,
  input  logic [CNT_W-1:0] word_bits,
  input  fmt_e             fmt,
  output logic [SMP_W-1:0] left_q,
  output logic [SMP_W-1:0] right_q
);
  logic [SMP_W-1:0] sh;
  logic [SMP_W-1:0] word;

  assign word = word_extract(fmt, sh, word_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      if (word_end) begin
        if (end_left) left_q  <= word;
        else          right_q <= word;
      end
      if (shift_en) sh <= {sh[SMP_W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/pcm_out_stage.sv
module pcm_out_stage #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_left  <= in_left;
      out_right <= in_right;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
  import pcm_rx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk_in,
  input  logic               lrclk_in,
  input  logic [LANES-1:0]   sdata_in,
  input  logic [1:0]         fmt_sel,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [32*LANES-1:0] out_left,
  output logic [32*LANES-1:0] out_right
);
  localparam int BUS_W  = SMP_W * LANES;
  localparam int SYNC_W = LANES + 2;

  logic [SYNC_W-1:0] sync_q;
  logic [LANES-1:0]  data_s;
  logic              bclk_s;
  logic              lr_s;
  fmt_e              fmt;
  logic              shift_en;
  logic              word_end;
  logic              end_left;
  logic [CNT_W-1:0]  word_bits;
  logic              frame_done;
  logic [BUS_W-1:0]  lane_left;
  logic [BUS_W-1:0]  lane_right;

  assign fmt = fmt_e'(fmt_sel);

  pcm_sync #(.W(SYNC_W)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sdata_in, lrclk_in, bclk_in}),
    .sync_out (sync_q)
  );

  assign bclk_s = sync_q[0];
  assign lr_s   = sync_q[1];
  assign data_s = sync_q[SYNC_W-1:2];

  pcm_frame_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_s     (bclk_s),
    .lr_s       (lr_s),
    .fmt        (fmt),
    .shift_en   (shift_en),
    .word_end   (word_end),
    .end_left   (end_left),
    .word_bits  (word_bits),
    .frame_done (frame_done)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pcm_lane i_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_in    (data_s[k]),
      .shift_en  (shift_en),
      .word_end  (word_end),
      .end_left  (end_left),
      .word_bits (word_bits),
      .fmt       (fmt),
      .left_q    (lane_left[SMP_W*k +: SMP_W]),
      .right_q   (lane_right[SMP_W*k +: SMP_W])
    );
  end

  pcm_out_stage #(.W(BUS_W)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_done),
    .in_left   (lane_left),
    .in_right  (lane_right),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );
endmodule

// File: rtl/pcm_rx_checks.sv
module pcm_rx_checks #(
  parameter int LANES = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [32*LANES-1:0] out_left,
  input logic [32*LANES-1:0] out_right,
  input logic                frame_done
);
  // R8: a stalled result is not withdrawn
  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R8: stalled data does not change unless a new frame lands
  a_r8_stable_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !frame_done |=> $stable(out_left) && $stable(out_right));

  // R8: handshake with no new frame clears valid
  a_r8_release_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frame_done |=> !out_valid);

  // R7: one frame completion is a single-cycle event
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7: a frame completion always presents a result
  a_r7_done_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid);
endmodule

bind serial_pcm_rx pcm_rx_checks #(.LANES(LANES)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_left   (out_left),
  .out_right  (out_right),
  .frame_done (frame_done)
);

// File: tb/test_serial_pcm_rx.sv
module test_serial_pcm_rx;
  localparam int LN = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bclk = 1'b0;
  logic            lrclk = 1'b0;
  logic [LN-1:0]   sdata = '0;
  logic [1:0]      fmt_sel = 2'd0;
  logic            out_ready = 1'b1;
  logic            out_valid;
  logic [32*LN-1:0] out_left;
  logic [32*LN-1:0] out_right;

  int errors = 0;
  int checks = 0;
  int nout = 0;
  bit finished = 0;
  logic [32*LN-1:0] cap_l, cap_r;

  always #5 clk = ~clk;

  serial_pcm_rx #(.LANES(LN)) i_serial_pcm_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrclk_in(lrclk),
    .sdata_in(sdata), .fmt_sel(fmt_sel), .out_ready(out_ready),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  // {fmt, slot, i2s length, left raw, right raw}
  localparam logic [81:0] VEC [8] = '{
    {2'd0, 8'd32, 8'd0,  32'hABCD_8001, 32'h1234_7FFF},
    {2'd0, 8'd16, 8'd0,  32'h0000_FFFF, 32'h0000_0001},
    {2'd1, 8'd32, 8'd0,  32'hF0F8_0000, 32'h0007_FFFF},
    {2'd2, 8'd32, 8'd0,  32'h0080_0001, 32'h557F_FFFE},
    {2'd2, 8'd24, 8'd0,  32'hFFFF_FFFF, 32'h0012_3456},
    {2'd3, 8'd32, 8'd24, 32'h8765_43A9, 32'h1234_56C7},
    {2'd3, 8'd33, 8'd32, 32'hDEAD_BEEF, 32'h8000_0001},
    {2'd3, 8'd17, 8'd16, 32'hC3A5_9999, 32'h7FFF_1234}
  };

  function automatic logic lr_at(input logic [1:0] f, input int slot, input int p);
    return (f == 2'd3) ? (p >= slot) : (p < slot);
  endfunction

  function automatic logic bit_at(input logic [1:0] f, input int slot, input int ilen,
                                  input int p, input logic [31:0] lw, input logic [31:0] rw);
    int n, q, i;
    logic [31:0] w;
    if (f != 2'd3) begin
      n = (f == 2'd0) ? 16 : (f == 2'd1) ? 20 : 24;
      q = (p >= slot) ? p - slot : p;
      w = (p >= slot) ? rw : lw;
      if (q >= slot - n) return w[n-1-(q-(slot-n))];
      return q[0];
    end
    if (p == 0) return 1'b0;
    if (p <= slot) begin i = p - 1; w = lw; end
    else begin i = p - slot - 1; w = rw; end
    if (i < ilen) return w[31-i];
    return (i >= 32);
  endfunction

  function automatic logic [31:0] exp_word(input logic [1:0] f, input int ilen, input logic [31:0] raw);
    case (f)
      2'd0: return {{16{raw[15]}}, raw[15:0]};
      2'd1: return {{12{raw[19]}}, raw[19:0]};
      2'd2: return {{8{raw[23]}}, raw[23:0]};
      default: return raw & ~(32'hFFFF_FFFF >> ilen);
    endcase
  endfunction

  function automatic logic [31:0] lane_mix(input logic [31:0] w, input int k);
    return w ^ (32'h1357_9BDF << k);
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input int slot, input int ilen,
                            input logic [31:0] lw, input logic [31:0] rw);
    logic [LN-1:0] d;
    for (int p = 0; p < 2*slot; p++) begin
      for (int k = 0; k < LN; k++) d[k] = bit_at(f, slot, ilen, p, lane_mix(lw, k), lane_mix(rw, k));
      lrclk = lr_at(f, slot, p);
      sdata = d;
      #40 bclk = 1'b1;
      #40 bclk = 1'b0;
    end
  endtask

  task automatic run_stream(input logic [1:0] f, input int slot, input int ilen,
                            input logic [31:0] la, input logic [31:0] ra,
                            input logic [31:0] lb, input logic [31:0] rb, input bit two);
    fmt_sel = f;
    bclk = 1'b0;
    sdata = '0;
    lrclk = lr_at(f, slot, 0);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nout = 0;
    send_frame(f, slot, ilen, ~la, ~ra);
    send_frame(f, slot, ilen, la, ra);
    if (two) send_frame(f, slot, ilen, lb, rb);
    send_frame(f, slot, ilen, 32'h5A5A_5A5A, 32'hA5A5_A5A5);
    repeat (20) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      cap_l = out_left;
      cap_r = out_right;
      nout++;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check_eq("R9 valid in reset", {31'd0, out_valid}, 32'd0);
    check_eq("R9 left in reset", out_left[31:0], 32'd0);
    check_eq("R9 right in reset", out_right[95:64], 32'd0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      logic [1:0] f;
      int slot, ilen;
      logic [31:0] lw, rw;
      f = VEC[v][81:80];
      slot = int'(VEC[v][79:72]);
      ilen = int'(VEC[v][71:64]);
      lw = VEC[v][63:32];
      rw = VEC[v][31:0];
      out_ready = 1'b1;
      run_stream(f, slot, ilen, lw, rw, 32'd0, 32'd0, 1'b0);
      // R7: only the full frame yields one result, partial head frame yields none
      check_eq("R7 result count", nout, 32'd1);
      for (int k = 0; k < LN; k++) begin
        // R1 R2 R3 (right-justified) or R1 R4 R5 (I2S), per lane R6
        check_eq((f == 2'd3) ? "R4 R5 R6 left" : "R2 R3 R6 left",
                 cap_l[32*k +: 32], exp_word(f, ilen, lane_mix(lw, k)));
        check_eq((f == 2'd3) ? "R4 R5 R6 right" : "R2 R3 R6 right",
                 cap_r[32*k +: 32], exp_word(f, ilen, lane_mix(rw, k)));
      end
    end

    // R8: back-pressure, overwrite while held, release after handshake
    out_ready = 1'b0;
    run_stream(2'd3, 32, 24, 32'h1111_2222, 32'h3333_4444,
               32'h8888_9999, 32'hAAAA_BBBB, 1'b1);
    check_eq("R8 no handshake while stalled", nout, 32'd0);
    check_eq("R8 valid held", {31'd0, out_valid}, 32'd1);
    check_eq("R8 overwrite left", out_left[31:0], exp_word(2'd3, 24, lane_mix(32'h8888_9999, 0)));
    check_eq("R8 overwrite right", out_right[63:32], exp_word(2'd3, 24, lane_mix(32'hAAAA_BBBB, 1)));
    out_ready = 1'b1;
    @(negedge clk);
    check_eq("R8 one handshake", nout, 32'd1);
    check_eq("R8 valid released", {31'd0, out_valid}, 32'd0);

    // R9: reset clears a held result
    out_ready = 1'b0;
    run_stream(2'd0, 32, 0, 32'h0000_1234, 32'h0000_8765, 32'd0, 32'd0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_eq("R9 valid cleared", {31'd0, out_valid}, 32'd0);
    check_eq("R9 data cleared", out_left[31:0] | out_right[31:0], 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule